// File: doc/BRIEF.md
# Multi-page-size TLB lookup unit

This block is a fully associative, unified translation lookaside buffer. It holds a parameterised number of entries, 64 by default. Each entry describes one page of 1 KB, 4 KB, 64 KB or 1 MB. An entry carries:
- a virtual page number and a physical page number;
- an 8-bit address-space tag and a global (shared) flag;
- a two-bit access-rights field and a modified flag;
- a valid flag.

Each lookup request presents a virtual address, a read/write direction, the running address-space tag, the privilege level and a single-address-space mode flag. One cycle later the block returns a registered result: the physical address, a granted flag and a fault code.

The entries are compared against the request by address range, and each entry's own page size sets the range. The address-space tag is ignored for global pages, and also when the core is privileged in single-address-space mode. A request that matches more than one entry is reported as a fault of its own. A replacement pointer steps on every lookup and wraps at a programmable bound. Software loads new entries through a one-cycle write port at the slot that the pointer names.

Top module: `tlb_lookup_unit`

## Requirements
- R1: After reset every entry is invalid, `repl_idx` is 0 and `rsp_valid` and `rsp_hit` are 0.
- R2: A request with `req_valid` high produces `rsp_valid` high for exactly one cycle, in the following cycle. With no request there is no response.
- R3: `wr_size` encodes the page size as 00 = 1 KB, 01 = 4 KB, 10 = 64 KB and 11 = 1 MB. A valid entry covers every address whose bits above the page offset equal those of `{vpn, 10'b0}`. Stored VPN bits that fall inside the offset are ignored.
- R4: On a granted access `rsp_paddr` is `{ppn, 10'b0}` with the page-offset bits replaced by the request's offset bits. On any fault it is 0.
- R5: The entry tag is compared with `req_asid` only when the entry is not global and address-space checking is on. Checking is on unless both `req_single_vm` and `req_priv` are 1.
- R6: When two or more entries match, the code is 0x140. This has priority over every other code.
- R7: When no valid entry matches, the code is 0x040 for a read and 0x060 for a write. Invalid entries never match.
- R8: In user mode (`req_priv` = 0), a single match whose rights bit 1 is 0 gives code 0x0A0 for a read and 0x0C0 for a write.
- R9: A write that passes R8 to an entry whose rights bit 0 is 0 gives code 0x0C0.
- R10: A write that passes R8 and R9 to an entry whose modified flag is 0 gives code 0x080.
- R11: An access with none of the faults above sets `rsp_hit` to 1 and gives code 0x000. `rsp_hit` is 0 whenever the code is non-zero.
- R12: `repl_idx` advances by one on each lookup. It becomes 0 instead when the advanced value would exceed a non-zero `repl_limit`, or would exceed ENTRIES-1. Writes and idle cycles leave it unchanged.
- R13: With `wr_en` high, the entry at `repl_idx` is replaced in one cycle, and later lookups see the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | VA_W | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_asid | input | ASID_W | Running address-space tag |
| req_priv | input | 1 | Privileged mode |
| req_single_vm | input | 1 | Single-address-space mode |
| repl_limit | input | IDX_W | Replacement wrap bound, 0 = full range |
| wr_en | input | 1 | Entry write strobe |
| wr_vpn | input | VA_W-10 | Virtual page number to store |
| wr_asid | input | ASID_W | Address-space tag to store |
| wr_ppn | input | PA_W-10 | Physical page number to store |
| wr_valid | input | 1 | Valid flag to store |
| wr_shared | input | 1 | Global flag to store |
| wr_size | input | 2 | Page size code to store |
| wr_prot | input | 2 | Access rights to store (bit 1 user, bit 0 write) |
| wr_dirty | input | 1 | Modified flag to store |
| rsp_valid | output | 1 | Result strobe |
| rsp_hit | output | 1 | Access granted |
| rsp_code | output | 12 | Fault code, 0 when granted |
| rsp_paddr | output | PA_W | Physical address |
| repl_idx | output | IDX_W | Replacement pointer / write slot |

## Verification
The bound checker checks the following on every cycle:
- the response timing and its direction-consistent codes: a read never sees a write-only code, and a privileged read never sees a user-rights violation;
- the pass-through of the low offset bits on grants, and a zero address on faults;
- the pointer either stepping by one or wrapping, and never leaving the programmed bound.

Some behaviours depend on table contents, and only the bench's scenarios can show them. These are the page-range matching for each size code, the tag bypass for global pages and single-space privileged mode, multiple-match detection, and the priority among the rights faults. The bench sweeps each of these against an arithmetic model of the table.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

   localparam int unsigned PAGE_BASE_LSB = 10;
   localparam int unsigned CODE_W        = 12;

   typedef enum logic [1:0] {
      SZ_1K  = 2'b00,
      SZ_4K  = 2'b01,
      SZ_64K = 2'b10,
      SZ_1M  = 2'b11
   } page_sz_e;

   localparam logic [CODE_W-1:0] FC_NONE     = 12'h000;
   localparam logic [CODE_W-1:0] FC_MISS_RD  = 12'h040;
   localparam logic [CODE_W-1:0] FC_MISS_WR  = 12'h060;
   localparam logic [CODE_W-1:0] FC_FIRST_WR = 12'h080;
   localparam logic [CODE_W-1:0] FC_PROT_RD  = 12'h0A0;
   localparam logic [CODE_W-1:0] FC_PROT_WR  = 12'h0C0;
   localparam logic [CODE_W-1:0] FC_MULTI    = 12'h140;

   // lowest address bit above the page offset for a size code
   function automatic int unsigned page_lsb(input logic [1:0] sz);
      case (page_sz_e'(sz))
         SZ_1K:   return 10;
         SZ_4K:   return 12;
         SZ_64K:  return 16;
         default: return 20;
      endcase
   endfunction

endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
   import tlb_pkg::*;
#(
   parameter int unsigned ENTRIES = 64,
   parameter int unsigned VPN_W   = 22,
   parameter int unsigned PPN_W   = 19,
   parameter int unsigned ASID_W  = 8,
   parameter int unsigned IDX_W   = 6
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr_en,
   input  logic [IDX_W-1:0]                  wr_idx,
   input  logic [VPN_W-1:0]                  wr_vpn,
   input  logic [ASID_W-1:0]                 wr_asid,
   input  logic [PPN_W-1:0]                  wr_ppn,
   input  logic                              wr_valid,
   input  logic                              wr_shared,
   input  logic [1:0]                        wr_size,
   input  logic [1:0]                        wr_prot,
   input  logic                              wr_dirty,
   input  logic [VPN_W-1:0]                  lk_vpn,
   input  logic [ASID_W-1:0]                 lk_asid,
   input  logic                              lk_asid_chk,
   output logic [ENTRIES-1:0]                match_vec,
   output logic [ENTRIES-1:0][PPN_W-1:0]     ent_ppn,
   output logic [ENTRIES-1:0][1:0]           ent_size,
   output logic [ENTRIES-1:0][1:0]           ent_prot,
   output logic [ENTRIES-1:0]                ent_dirty
);

   function automatic logic [VPN_W-1:0] keep_mask(input logic [1:0] sz);
      return {VPN_W{1'b1}} << (page_lsb(sz) - PAGE_BASE_LSB);
   endfunction

   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      logic                v_q;
      logic                sh_q;
      logic                d_q;
      logic [1:0]          sz_q;
      logic [1:0]          pr_q;
      logic [VPN_W-1:0]    vpn_q;
      logic [ASID_W-1:0]   asid_q;
      logic [PPN_W-1:0]    ppn_q;
      logic                sel;
      logic [VPN_W-1:0]    keep;
      logic                tag_ok;

      assign sel = wr_en && (wr_idx == IDX_W'(e));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q    <= 1'b0;
            sh_q   <= 1'b0;
            d_q    <= 1'b0;
            sz_q   <= 2'b00;
            pr_q   <= 2'b00;
            vpn_q  <= '0;
            asid_q <= '0;
            ppn_q  <= '0;
         end else if (sel) begin
            v_q    <= wr_valid;
            sh_q   <= wr_shared;
            d_q    <= wr_dirty;
            sz_q   <= wr_size;
            pr_q   <= wr_prot;
            vpn_q  <= wr_vpn;
            asid_q <= wr_asid;
            ppn_q  <= wr_ppn;
         end
      end

      assign keep         = keep_mask(sz_q);
      assign tag_ok       = sh_q || !lk_asid_chk || (asid_q == lk_asid);
      assign match_vec[e] = v_q && tag_ok && ((lk_vpn & keep) == (vpn_q & keep));
      assign ent_ppn[e]   = ppn_q;
      assign ent_size[e]  = sz_q;
      assign ent_prot[e]  = pr_q;
      assign ent_dirty[e] = d_q;
   end

endmodule

// File: rtl/tlb_hit_select.sv
module tlb_hit_select #(
   parameter int unsigned ENTRIES   = 64,
   parameter int unsigned PPN_W     = 19,
   parameter int unsigned IDX_W     = 6,
   parameter int unsigned SEL_STYLE = 0
) (
   input  logic [ENTRIES-1:0]             match_vec,
   input  logic [ENTRIES-1:0][PPN_W-1:0]  ent_ppn,
   input  logic [ENTRIES-1:0][1:0]        ent_size,
   input  logic [ENTRIES-1:0][1:0]        ent_prot,
   input  logic [ENTRIES-1:0]             ent_dirty,
   output logic                           any_hit,
   output logic                           multi_hit,
   output logic [PPN_W-1:0]               sel_ppn,
   output logic [1:0]                     sel_size,
   output logic [1:0]                     sel_prot,
   output logic                           sel_dirty
);

   // match counting shared by both selection variants
   always_comb begin
      any_hit   = 1'b0;
      multi_hit = 1'b0;
      for (int e = 0; e < ENTRIES; e++) begin
         if (match_vec[e]) begin
            if (any_hit) multi_hit = 1'b1;
            any_hit = 1'b1;
         end
      end
   end

   if (SEL_STYLE == 0) begin : g_andor
      // flat AND-OR mux: shallow, valid when at most one entry matches
      always_comb begin
         sel_ppn   = '0;
         sel_size  = 2'b00;
         sel_prot  = 2'b00;
         sel_dirty = 1'b0;
         for (int e = 0; e < ENTRIES; e++) begin
            sel_ppn   = sel_ppn  | (ent_ppn[e]  & {PPN_W{match_vec[e]}});
            sel_size  = sel_size | (ent_size[e] & {2{match_vec[e]}});
            sel_prot  = sel_prot | (ent_prot[e] & {2{match_vec[e]}});
            sel_dirty = sel_dirty | (ent_dirty[e] & match_vec[e]);
         end
      end
   end else begin : g_prio
      // encoded index then indexed mux: lowest matching entry wins
      logic [IDX_W-1:0] hit_idx;
      always_comb begin
         hit_idx = '0;
         for (int e = ENTRIES - 1; e >= 0; e--) begin
            if (match_vec[e]) hit_idx = IDX_W'(e);
         end
      end
      assign sel_ppn   = ent_ppn[hit_idx];
      assign sel_size  = ent_size[hit_idx];
      assign sel_prot  = ent_prot[hit_idx];
      assign sel_dirty = ent_dirty[hit_idx];
   end

endmodule

// File: rtl/tlb_perm_check.sv
module tlb_perm_check
   import tlb_pkg::*;
(
   input  logic               any_hit,
   input  logic               multi_hit,
   input  logic               is_write,
   input  logic               priv,
   input  logic [1:0]         prot,
   input  logic               dirty,
   output logic               grant,
   output logic [CODE_W-1:0]  code
);

   always_comb begin
      grant = 1'b0;
      code  = FC_NONE;
      if (multi_hit) begin
         code = FC_MULTI;
      end else if (!any_hit) begin
         code = is_write ? FC_MISS_WR : FC_MISS_RD;
      end else if (!priv && !prot[1]) begin
         code = is_write ? FC_PROT_WR : FC_PROT_RD;
      end else if (is_write && !prot[0]) begin
         code = FC_PROT_WR;
      end else if (is_write && !dirty) begin
         code = FC_FIRST_WR;
      end else begin
         grant = 1'b1;
      end
   end

endmodule

// File: rtl/tlb_repl_ctr.sv
module tlb_repl_ctr #(
   parameter int unsigned ENTRIES = 64,
   parameter int unsigned IDX_W   = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic [IDX_W-1:0]  limit,
   output logic [IDX_W-1:0]  idx
);

   localparam logic [IDX_W:0] TOP = (IDX_W+1)'(ENTRIES - 1);

   logic [IDX_W:0] inc;
   logic           wrap;

   assign inc  = {1'b0, idx} + 1'b1;
   assign wrap = ((limit != '0) && (inc > {1'b0, limit})) || (inc > TOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    idx <= '0;
      else if (step) idx <= wrap ? '0 : inc[IDX_W-1:0];
   end

endmodule

// File: rtl/tlb_lookup_unit.sv
module tlb_lookup_unit
   import tlb_pkg::*;
#(
   parameter  int unsigned ENTRIES   = 64,
   parameter  int unsigned VA_W      = 32,
   parameter  int unsigned PA_W      = 29,
   parameter  int unsigned ASID_W    = 8,
   parameter  int unsigned SEL_STYLE = 0,
   localparam int unsigned IDX_W     = $clog2(ENTRIES),
   localparam int unsigned VPN_W     = VA_W - PAGE_BASE_LSB,
   localparam int unsigned PPN_W     = PA_W - PAGE_BASE_LSB
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [VA_W-1:0]    req_addr,
   input  logic               req_write,
   input  logic [ASID_W-1:0]  req_asid,
   input  logic               req_priv,
   input  logic               req_single_vm,
   input  logic [IDX_W-1:0]   repl_limit,
   input  logic               wr_en,
   input  logic [VPN_W-1:0]   wr_vpn,
   input  logic [ASID_W-1:0]  wr_asid,
   input  logic [PPN_W-1:0]   wr_ppn,
   input  logic               wr_valid,
   input  logic               wr_shared,
   input  logic [1:0]         wr_size,
   input  logic [1:0]         wr_prot,
   input  logic               wr_dirty,
   output logic               rsp_valid,
   output logic               rsp_hit,
   output logic [CODE_W-1:0]  rsp_code,
   output logic [PA_W-1:0]    rsp_paddr,
   output logic [IDX_W-1:0]   repl_idx
);

   // elaboration-time parameter checks
   if (ENTRIES < 2 || ENTRIES > 64 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_bad_entries
      $error("ENTRIES must be a power of two from 2 to 64");
   end
   if (VA_W < 21 || VA_W > 64) begin : g_bad_va
      $error("VA_W must cover a 1 MB page plus one page bit");
   end
   if (PA_W < 21 || PA_W > VA_W) begin : g_bad_pa
      $error("PA_W must be between 21 and VA_W");
   end
   if (ASID_W < 1 || ASID_W > 16) begin : g_bad_asid
      $error("ASID_W out of range");
   end
   if (SEL_STYLE > 1) begin : g_bad_sel
      $error("SEL_STYLE must be 0 or 1");
   end

   logic [ENTRIES-1:0]             match_vec;
   logic [ENTRIES-1:0][PPN_W-1:0]  ent_ppn;
   logic [ENTRIES-1:0][1:0]        ent_size;
   logic [ENTRIES-1:0][1:0]        ent_prot;
   logic [ENTRIES-1:0]             ent_dirty;
   logic                           any_hit;
   logic                           multi_hit;
   logic [PPN_W-1:0]               sel_ppn;
   logic [1:0]                     sel_size;
   logic [1:0]                     sel_prot;
   logic                           sel_dirty;
   logic                           grant;
   logic [CODE_W-1:0]              code;
   logic                           asid_chk;
   logic [PA_W-1:0]                off_mask;
   logic [PA_W-1:0]                frame_pa;
   logic [PA_W-1:0]                pa_c;

   assign asid_chk = !(req_single_vm && req_priv);

   tlb_entry_store #(
      .ENTRIES (ENTRIES),
      .VPN_W   (VPN_W),
      .PPN_W   (PPN_W),
      .ASID_W  (ASID_W),
      .IDX_W   (IDX_W)
   ) u_store (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_idx      (repl_idx),
      .wr_vpn      (wr_vpn),
      .wr_asid     (wr_asid),
      .wr_ppn      (wr_ppn),
      .wr_valid    (wr_valid),
      .wr_shared   (wr_shared),
      .wr_size     (wr_size),
      .wr_prot     (wr_prot),
      .wr_dirty    (wr_dirty),
      .lk_vpn      (req_addr[VA_W-1:PAGE_BASE_LSB]),
      .lk_asid     (req_asid),
      .lk_asid_chk (asid_chk),
      .match_vec   (match_vec),
      .ent_ppn     (ent_ppn),
      .ent_size    (ent_size),
      .ent_prot    (ent_prot),
      .ent_dirty   (ent_dirty)
   );

   tlb_hit_select #(
      .ENTRIES   (ENTRIES),
      .PPN_W     (PPN_W),
      .IDX_W     (IDX_W),
      .SEL_STYLE (SEL_STYLE)
   ) u_select (
      .match_vec (match_vec),
      .ent_ppn   (ent_ppn),
      .ent_size  (ent_size),
      .ent_prot  (ent_prot),
      .ent_dirty (ent_dirty),
      .any_hit   (any_hit),
      .multi_hit (multi_hit),
      .sel_ppn   (sel_ppn),
      .sel_size  (sel_size),
      .sel_prot  (sel_prot),
      .sel_dirty (sel_dirty)
   );

   tlb_perm_check u_perm (
      .any_hit   (any_hit),
      .multi_hit (multi_hit),
      .is_write  (req_write),
      .priv      (req_priv),
      .prot      (sel_prot),
      .dirty     (sel_dirty),
      .grant     (grant),
      .code      (code)
   );

   tlb_repl_ctr #(
      .ENTRIES (ENTRIES),
      .IDX_W   (IDX_W)
   ) u_repl (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (req_valid),
      .limit (repl_limit),
      .idx   (repl_idx)
   );

   // physical address: frame bits above the page offset, offset from request
   assign off_mask = ~({PA_W{1'b1}} << page_lsb(sel_size));
   assign frame_pa = {sel_ppn, {PAGE_BASE_LSB{1'b0}}};
   assign pa_c     = (frame_pa & ~off_mask) | (req_addr[PA_W-1:0] & off_mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_code  <= FC_NONE;
         rsp_paddr <= '0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_hit   <= grant;
            rsp_code  <= code;
            rsp_paddr <= grant ? pa_c : '0;
         end
      end
   end

endmodule

// File: rtl/tlb_lookup_unit_chk.sv
module tlb_lookup_unit_chk #(
   parameter int unsigned VA_W  = 32,
   parameter int unsigned PA_W  = 29,
   parameter int unsigned IDX_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic [VA_W-1:0]  req_addr,
   input logic             req_write,
   input logic             req_priv,
   input logic [IDX_W-1:0] repl_limit,
   input logic             rsp_valid,
   input logic             rsp_hit,
   input logic [11:0]      rsp_code,
   input logic [PA_W-1:0]  rsp_paddr,
   input logic [IDX_W-1:0] repl_idx
);

   a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   a_r11_grant_code_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_hit |-> rsp_code == 12'h000);

   a_r11_fault_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_hit |-> rsp_code inside {12'h040, 12'h060, 12'h080, 12'h0A0, 12'h0C0, 12'h140});

   a_r4_offset_passthru: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_hit |-> rsp_paddr[9:0] == $past(req_addr[9:0]));

   a_r4_fault_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_hit |-> rsp_paddr == '0);

   a_r7_read_codes: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !$past(req_write) |-> !(rsp_code inside {12'h060, 12'h080, 12'h0C0}));

   a_r7_write_codes: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && $past(req_write) |-> !(rsp_code inside {12'h040, 12'h0A0}));

   a_r8_priv_read_no_viol: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && $past(req_priv) && !$past(req_write) |-> rsp_code != 12'h0A0);

   a_r12_step_or_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (repl_idx == '0) || (repl_idx == IDX_W'($past(repl_idx) + 1'b1)));

   a_r12_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> $stable(repl_idx));

   a_r12_within_limit: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && (repl_limit != '0) |=> repl_idx <= $past(repl_limit));

endmodule

bind tlb_lookup_unit tlb_lookup_unit_chk #(
   .VA_W  (VA_W),
   .PA_W  (PA_W),
   .IDX_W (IDX_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_addr   (req_addr),
   .req_write  (req_write),
   .req_priv   (req_priv),
   .repl_limit (repl_limit),
   .rsp_valid  (rsp_valid),
   .rsp_hit    (rsp_hit),
   .rsp_code   (rsp_code),
   .rsp_paddr  (rsp_paddr),
   .repl_idx   (repl_idx)
);

// File: tb/tlb_lookup_unit_tb_top.sv
module tlb_lookup_unit_tb_top;

   localparam int N = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic        req_write = 1'b0;
   logic [7:0]  req_asid = '0;
   logic        req_priv = 1'b0;
   logic        req_single_vm = 1'b0;
   logic [5:0]  repl_limit = '0;
   logic        wr_en = 1'b0;
   logic [21:0] wr_vpn = '0;
   logic [7:0]  wr_asid = '0;
   logic [18:0] wr_ppn = '0;
   logic        wr_valid = 1'b0;
   logic        wr_shared = 1'b0;
   logic [1:0]  wr_size = '0;
   logic [1:0]  wr_prot = '0;
   logic        wr_dirty = 1'b0;
   logic        rsp_valid;
   logic        rsp_hit;
   logic [11:0] rsp_code;
   logic [28:0] rsp_paddr;
   logic [5:0]  repl_idx;

   always #10 clk = ~clk;

   tlb_lookup_unit dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_write(req_write), .req_asid(req_asid), .req_priv(req_priv),
      .req_single_vm(req_single_vm), .repl_limit(repl_limit), .wr_en(wr_en),
      .wr_vpn(wr_vpn), .wr_asid(wr_asid), .wr_ppn(wr_ppn), .wr_valid(wr_valid),
      .wr_shared(wr_shared), .wr_size(wr_size), .wr_prot(wr_prot),
      .wr_dirty(wr_dirty), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
      .rsp_code(rsp_code), .rsp_paddr(rsp_paddr), .repl_idx(repl_idx)
   );

   int vectors = 0;
   int errors  = 0;

   // reference table and pointer
   logic        m_v   [N];
   logic        m_sh  [N];
   logic        m_d   [N];
   logic [1:0]  m_sz  [N];
   logic [1:0]  m_pr  [N];
   logic [21:0] m_vpn [N];
   logic [7:0]  m_asid[N];
   logic [18:0] m_ppn [N];
   int          m_cnt = 0;

   task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic int shift_of(input logic [1:0] sz);
      return (sz == 2'b00) ? 10 : (sz == 2'b01) ? 12 : (sz == 2'b10) ? 16 : 20;
   endfunction

   task automatic model(input logic [31:0] a, input logic w, input logic [7:0] asid,
                        input logic pv, input logic svm,
                        output logic [11:0] code, output logic hit, output logic [31:0] pa);
      int nm = 0;
      int idx = 0;
      int s;
      logic [31:0] fr;
      for (int e = 0; e < N; e++) begin
         s = shift_of(m_sz[e]);
         if (m_v[e] && ((a >> s) == ({m_vpn[e], 10'b0} >> s)) &&
             (m_sh[e] || (svm && pv) || (m_asid[e] == asid))) begin
            nm++;
            idx = e;
         end
      end
      hit = 1'b0;
      pa  = '0;
      if (nm > 1)                          code = 12'h140;
      else if (nm == 0)                    code = w ? 12'h060 : 12'h040;
      else if (!pv && !m_pr[idx][1])       code = w ? 12'h0C0 : 12'h0A0;
      else if (w && !m_pr[idx][0])         code = 12'h0C0;
      else if (w && !m_d[idx])             code = 12'h080;
      else begin
         code = 12'h000;
         hit  = 1'b1;
         s    = shift_of(m_sz[idx]);
         fr   = {3'b000, m_ppn[idx], 10'b0};
         pa   = ((fr >> s) << s) | (a & ((32'd1 << s) - 1));
      end
   endtask

   task automatic lookup(input string tag, input logic [31:0] a, input logic w,
                         input logic [7:0] asid, input logic pv, input logic svm);
      logic [11:0] ec;
      logic        eh;
      logic [31:0] ep;
      model(a, w, asid, pv, svm, ec, eh, ep);
      @(negedge clk);
      req_addr = a; req_write = w; req_asid = asid; req_priv = pv; req_single_vm = svm;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      begin
         int nx = m_cnt + 1;
         if ((repl_limit != 0 && nx > int'(repl_limit)) || nx > N - 1) nx = 0;
         m_cnt = nx;
      end
      check("R2", "rsp_valid", 32'(rsp_valid), 32'd1);
      check(tag, "code", 32'(rsp_code), 32'(ec));
      check("R11", "hit", 32'(rsp_hit), 32'(eh));
      check("R4", "paddr", 32'(rsp_paddr), ep);
      check("R12", "repl_idx", 32'(repl_idx), 32'(m_cnt));
   endtask

   task automatic write_entry(input logic [21:0] vpn, input logic [7:0] asid, input logic [18:0] ppn,
                              input logic v, input logic sh, input logic [1:0] sz,
                              input logic [1:0] pr, input logic d);
      @(negedge clk);
      wr_vpn = vpn; wr_asid = asid; wr_ppn = ppn; wr_valid = v; wr_shared = sh;
      wr_size = sz; wr_prot = pr; wr_dirty = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      m_vpn[m_cnt] = vpn; m_asid[m_cnt] = asid; m_ppn[m_cnt] = ppn; m_v[m_cnt] = v;
      m_sh[m_cnt] = sh; m_sz[m_cnt] = sz; m_pr[m_cnt] = pr; m_d[m_cnt] = d;
      check("R12", "idx unchanged by write", 32'(repl_idx), 32'(m_cnt));
   endtask

   task automatic place(input int i);
      while (m_cnt != i) lookup("R13", 32'hF000_0000, 1'b0, 8'h00, 1'b1, 1'b0);
   endtask

   initial begin
      for (int e = 0; e < N; e++) begin
         m_v[e] = 0; m_sh[e] = 0; m_d[e] = 0; m_sz[e] = 0; m_pr[e] = 0;
         m_vpn[e] = 0; m_asid[e] = 0; m_ppn[e] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1", "rsp_valid", 32'(rsp_valid), 0);
      check("R1", "rsp_hit", 32'(rsp_hit), 0);
      check("R1", "repl_idx", 32'(repl_idx), 0);
      lookup("R1", 32'h0000_0000, 1'b0, 8'h00, 1'b1, 1'b0);
      lookup("R7", 32'h1234_5678, 1'b1, 8'h00, 1'b0, 1'b0);
      @(negedge clk);
      check("R2", "no response when idle", 32'(rsp_valid), 0);

      // R12 pointer sweep: full range, then a bound of 5
      for (int k = 0; k < 70; k++) lookup("R12", 32'hF000_0000 + k, k[0], 8'h00, 1'b0, 1'b0);
      repl_limit = 6'd5;
      for (int k = 0; k < 14; k++) lookup("R12", 32'hF000_0000, 1'b0, 8'h00, 1'b1, 1'b0);
      repl_limit = 6'd0;

      // R3/R4 page sizes with offset-bit garbage in stored page numbers
      place(10); write_entry(22'h000400, 8'h11, 19'h12345, 1, 1, 2'b00, 2'b11, 1);
      place(11); write_entry(22'h000803, 8'h11, 19'h23457, 1, 1, 2'b01, 2'b11, 1);
      place(12); write_entry(22'h000C2A, 8'h11, 19'h3456B, 1, 1, 2'b10, 2'b11, 1);
      place(13); write_entry(22'h0042A5, 8'h11, 19'h456FF, 1, 1, 2'b11, 2'b11, 1);
      for (int s = 0; s < 4; s++) begin
         logic [31:0] base;
         logic [31:0] span;
         base = (s == 0) ? 32'h0010_0000 : (s == 1) ? 32'h0020_0000 :
                (s == 2) ? 32'h0030_0000 : 32'h0100_0000;
         span = 32'd1 << shift_of(2'(s));
         lookup("R3", base, 1'b0, 8'h99, 1'b0, 1'b0);
         lookup("R3", base + 1, 1'b1, 8'h99, 1'b0, 1'b0);
         lookup("R3", base + (span >> 1) + 3, 1'b0, 8'h5A, 1'b0, 1'b0);
         lookup("R3", base + span - 1, 1'b1, 8'h11, 1'b1, 1'b0);
         lookup("R3", base + span, 1'b0, 8'h11, 1'b0, 1'b0);
         lookup("R3", base - 1, 1'b0, 8'h11, 1'b0, 1'b0);
      end

      // R5 tag checking and bypass
      place(20); write_entry(22'h010000, 8'h33, 19'h00ABC, 1, 0, 2'b01, 2'b11, 1);
      lookup("R5", 32'h0400_0123, 1'b0, 8'h33, 1'b0, 1'b0);
      lookup("R5", 32'h0400_0123, 1'b0, 8'h44, 1'b0, 1'b0);
      lookup("R5", 32'h0400_0123, 1'b0, 8'h44, 1'b1, 1'b0);
      lookup("R5", 32'h0400_0123, 1'b1, 8'h44, 1'b1, 1'b1);
      lookup("R5", 32'h0400_0123, 1'b0, 8'h44, 1'b0, 1'b1);

      // R8/R9/R10 rights and modified flag over every combination
      for (int p = 0; p < 4; p++) begin
         place(30 + p);
         write_entry(22'h014000 + 22'(p * 4), 8'h00, 19'h01000 + 19'(p), 1, 1, 2'b01, 2'(p), (p == 3) ? 1'b0 : 1'b1);
      end
      for (int p = 0; p < 4; p++) begin
         for (int w = 0; w < 2; w++) begin
            for (int pv = 0; pv < 2; pv++) begin
               string tag;
               logic [1:0] pr;
               pr = 2'(p);
               if (pv == 0 && !pr[1])       tag = "R8";
               else if (w == 1 && !pr[0])   tag = "R9";
               else if (w == 1 && p == 3)   tag = "R10";
               else                         tag = "R11";
               lookup(tag, 32'h0500_0000 + 32'(p * 4096) + 32'h24, w[0], 8'h00, pv[0], 1'b0);
            end
         end
      end

      // R6 overlapping entries
      place(40); write_entry(22'h020000, 8'h00, 19'h07000, 1, 1, 2'b11, 2'b11, 1);
      place(41); write_entry(22'h020040, 8'h00, 19'h07F00, 1, 1, 2'b01, 2'b00, 0);
      lookup("R6", 32'h0801_0004, 1'b0, 8'h00, 1'b0, 1'b0);
      lookup("R6", 32'h0801_0FFC, 1'b1, 8'h00, 1'b1, 1'b0);
      lookup("R6", 32'h0802_0000, 1'b1, 8'h00, 1'b0, 1'b0);

      // R7 invalid entries never match; R13 overwrite takes effect
      place(50); write_entry(22'h024000, 8'h00, 19'h00001, 0, 1, 2'b11, 2'b11, 1);
      lookup("R7", 32'h0900_0000, 1'b0, 8'h00, 1'b1, 1'b0);
      lookup("R7", 32'h0900_0010, 1'b1, 8'h00, 1'b1, 1'b0);
      place(41); write_entry(22'h020040, 8'h00, 19'h07F00, 0, 1, 2'b01, 2'b00, 0);
      lookup("R13", 32'h0801_0004, 1'b0, 8'h00, 1'b0, 1'b0);
      place(41); write_entry(22'h028000, 8'h00, 19'h00222, 1, 1, 2'b00, 2'b11, 1);
      lookup("R13", 32'h0A00_0155, 1'b1, 8'h00, 1'b0, 1'b0);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      #(200000 * 20);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

endmodule